// File: doc/BRIEF.md
# Chainable Two-Edge PWM Timer with Input Capture

The block is a pulse-width timer. A prescale counter divides the clock, and each time it expires a period counter advances by one. The period counter runs from zero up to a programmed end value and then returns to zero. Every output has two compare positions of its own: one where it goes high and one where it goes low. Software writes period, prescale, compare and sync-delay values into shadow registers through a write-only register port. It then requests an update. The shadow set is copied into the working registers only at a period boundary, and only while the transfer-permit input is high.

Several timers can be chained. The sync output of one timer restarts the counters of the next timer through its sync input. The transfer-permit output of one timer gates the shadow transfer of the next timer. Capture inputs are synchronised, and each is edge-detected on a selectable polarity. On each detected edge the current counter value is latched. Period wraps and captures set sticky flags, and enabled flags drive a single interrupt line.

Two state machines carry the control. The counter machine has the states STOPPED and COUNTING. STOPPED moves to COUNTING when the run bit is set, and COUNTING moves back to STOPPED when the run bit is cleared. The update machine has the states NO_REQUEST and REQUEST_PENDING. NO_REQUEST moves to REQUEST_PENDING on a write of the request bit. REQUEST_PENDING moves back to NO_REQUEST when the shadow set is copied in, unless a fresh request arrives in that same cycle.

Top module: `sync_pwm_timer`

## Requirements
- R1: The register port maps its addresses as follows: address 0 is the period end value, address 1 is the prescale value, address 2 is control, address 3 is the sync delay, address 4 is flag clear, address 8+2k is the rise value of output k, and address 9+2k is the fall value of output k. With prescale P and end value N, the counter holds each value for P+1 clocks and counts 0, 1, …, N, 0.
- R2: Writes to addresses 0, 1, 3 and 8 and above only change shadow copies. Writing control with bit 1 set requests an update. A pending update is copied in at the next period wrap, or one clock later if the counter is stopped. Outside those moments the working values never change.
- R3: While the transfer-permit input is low, a pending update is never applied. The transfer-permit output goes high in the clock after a transfer. It goes low in the clock after the next wrap that carries no transfer.
- R4: An output goes high one clock after the counter equals its rise value and low one clock after the counter equals its fall value. If the rise and fall values are equal, the output stays low.
- R5: Each capture input passes through two synchroniser flops. Control bit 2+k selects the edge for input k: 0 means rising and 1 means falling. On a selected edge the counter value is latched into that input's capture register. Edges of the other polarity change nothing.
- R6: Flag 0 is set by a period wrap and flag 1+k by capture on input k. Writing a one to bit j at address 4 clears flag j. A set in the same clock wins over the clear.
- R7: The interrupt output is the OR of the flags whose enable bit is set. Flag j is enabled by control bit 8+j.
- R8: The sync output is a one-clock pulse in the first clock in which the counter holds the sync delay value D. With D = 0 it pulses at each wrap, at each restart and at each start.
- R9: A high sync input clears the prescale and period counters at that clock edge, so a chained timer restarts one clock after its master's sync pulse.
- R10: Control bit 0 runs the counter. When it is cleared, the counter reads zero from the following clock and every output is low one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counters |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| sync_in | input | 1 | Counter restart from a master timer |
| xfer_en_in | input | 1 | Transfer permit from a master timer |
| cap_in | input | NUM_CAP | Asynchronous capture inputs |
| pwm_out | output | NUM_OUT | Modulated outputs |
| cnt_value | output | CNT_W | Current period counter value |
| cap_value | output | NUM_CAP*CNT_W | Capture registers, input k at bits k*CNT_W upward |
| irq_flags | output | NUM_CAP+1 | Sticky flags: wrap at bit 0, capture k at bit 1+k |
| irq | output | 1 | Interrupt request |
| sync_out | output | 1 | Delayed period-start pulse for a slave |
| xfer_en_out | output | 1 | Transfer permit for a slave |

## Verification
The hardest situation to reach is the chained transfer. A slave's update request has to stay pending across many of its own wraps, while its master has not yet transferred. The slave must then take the update at its first wrap after the master's transfer. The bench reaches this state with two instances wired master to slave. It gives the slave a zero end value, which makes it wrap every clock, and leaves a request pending. It confirms the slave's counter stays at zero, then requests an update on the master and waits for the slave's counter to climb to its new end value. Capture timing is pinned down by restarting the counter through the sync input at a known clock, so that the latched value is a fixed number.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
    typedef enum logic {CNT_IDLE, CNT_RUN} cnt_state_t;
    typedef enum logic {UPD_IDLE, UPD_PEND} upd_state_t;

    localparam int ADR_PERIOD   = 0;
    localparam int ADR_PRESC    = 1;
    localparam int ADR_CTRL     = 2;
    localparam int ADR_SDLY     = 3;
    localparam int ADR_FCLR     = 4;
    localparam int ADR_CMP_BASE = 8;

    localparam int CTL_RUN      = 0;
    localparam int CTL_UPD      = 1;
    localparam int CTL_EDGE_LSB = 2;
    localparam int CTL_IEN_LSB  = 8;
endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
    import spwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_OUT = 2,
    parameter int NUM_CAP = 2,
    parameter int ADDR_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CNT_W-1:0]         wr_data,
    input  logic                     wrap,
    input  logic                     running,
    input  logic                     xfer_in,
    output logic [CNT_W-1:0]         act_period,
    output logic [CNT_W-1:0]         act_presc,
    output logic [CNT_W-1:0]         act_sdly,
    output logic [NUM_OUT*CNT_W-1:0] act_rise,
    output logic [NUM_OUT*CNT_W-1:0] act_fall,
    output logic                     run_en,
    output logic [NUM_CAP-1:0]       edge_sel,
    output logic [NUM_CAP:0]         irq_en,
    output logic [NUM_CAP:0]         flag_clr,
    output logic                     xfer_out
);
    localparam int NUM_FLG = NUM_CAP + 1;

    logic [CNT_W-1:0] sh_period, sh_presc, sh_sdly;
    logic [CNT_W-1:0] period_q, presc_q, sdly_q;
    logic [CNT_W-1:0] sh_rise [NUM_OUT];
    logic [CNT_W-1:0] sh_fall [NUM_OUT];
    logic [CNT_W-1:0] rise_q  [NUM_OUT];
    logic [CNT_W-1:0] fall_q  [NUM_OUT];

    upd_state_t upd_q, upd_d;
    logic       ctrl_wr, upd_req, load;
    logic       run_q, xfer_q;
    logic [NUM_CAP-1:0] edge_q;
    logic [NUM_FLG-1:0] ien_q;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
    assign upd_req = ctrl_wr && wr_data[CTL_UPD];
    assign load    = (upd_q == UPD_PEND) && xfer_in && (wrap || !running);

    // update state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_q <= UPD_IDLE;
        else        upd_q <= upd_d;
    end

    // update next-state logic
    always_comb begin
        upd_d = upd_q;
        unique case (upd_q)
            UPD_IDLE: if (upd_req) upd_d = UPD_PEND;
            UPD_PEND: if (load && !upd_req) upd_d = UPD_IDLE;
            default:  upd_d = UPD_IDLE;
        endcase
    end

    // shadow and working copies of the shared settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_period <= '0;
            sh_presc  <= '0;
            sh_sdly   <= '0;
            period_q  <= '0;
            presc_q   <= '0;
            sdly_q    <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_W'(ADR_PERIOD)) sh_period <= wr_data;
            if (wr_en && wr_addr == ADDR_W'(ADR_PRESC))  sh_presc  <= wr_data;
            if (wr_en && wr_addr == ADDR_W'(ADR_SDLY))   sh_sdly   <= wr_data;
            if (load) begin
                period_q <= sh_period;
                presc_q  <= sh_presc;
                sdly_q   <= sh_sdly;
            end
        end
    end

    // per-output compare pairs
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_rise[i] <= '0;
                sh_fall[i] <= '0;
                rise_q[i]  <= '0;
                fall_q[i]  <= '0;
            end else begin
                if (wr_en && wr_addr == ADDR_W'(ADR_CMP_BASE + 2*i))     sh_rise[i] <= wr_data;
                if (wr_en && wr_addr == ADDR_W'(ADR_CMP_BASE + 2*i + 1)) sh_fall[i] <= wr_data;
                if (load) begin
                    rise_q[i] <= sh_rise[i];
                    fall_q[i] <= sh_fall[i];
                end
            end
        end
        assign act_rise[i*CNT_W +: CNT_W] = rise_q[i];
        assign act_fall[i*CNT_W +: CNT_W] = fall_q[i];
    end

    // control bits that act at once, and the permit for a chained slave
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            edge_q <= '0;
            ien_q  <= '0;
            xfer_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                run_q  <= wr_data[CTL_RUN];
                edge_q <= wr_data[CTL_EDGE_LSB +: NUM_CAP];
                ien_q  <= wr_data[CTL_IEN_LSB +: NUM_FLG];
            end
            if (load)      xfer_q <= 1'b1;
            else if (wrap) xfer_q <= 1'b0;
        end
    end

    assign act_period = period_q;
    assign act_presc  = presc_q;
    assign act_sdly   = sdly_q;
    assign run_en     = run_q;
    assign edge_sel   = edge_q;
    assign irq_en     = ien_q;
    assign xfer_out   = xfer_q;
    assign flag_clr   = (wr_en && wr_addr == ADDR_W'(ADR_FCLR)) ? wr_data[NUM_FLG-1:0] : '0;

    // R3: no working value changes while the permit is low
    a_r3_no_load_without_permit: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_in |=> $stable(period_q));
    // R2: working values hold in the middle of a running period
    a_r2_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> ($stable(period_q) && $stable(presc_q)));
endmodule

// File: rtl/spwm_counter.sv
module spwm_counter
    import spwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] presc,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] sdly,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             running,
    output logic             sync_pulse
);
    cnt_state_t st_q, st_d;
    logic [CNT_W-1:0] pre_q, cnt_q, cnt_nxt;
    logic active, restart, start, tick, at_end, sync_q;

    // counter state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CNT_IDLE;
        else        st_q <= st_d;
    end

    // counter next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CNT_IDLE: if (run_en)  st_d = CNT_RUN;
            CNT_RUN:  if (!run_en) st_d = CNT_IDLE;
            default:  st_d = CNT_IDLE;
        endcase
    end

    assign active  = (st_q == CNT_RUN) && run_en;
    assign start   = (st_q == CNT_IDLE) && run_en;
    assign restart = active && sync_in;
    assign tick    = active && !sync_in && (pre_q >= presc);
    assign at_end  = (cnt_q >= period);
    assign wrap    = tick && at_end;
    assign cnt_nxt = at_end ? '0 : cnt_q + 1'b1;

    // prescale and period counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (!active || sync_in) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= cnt_nxt;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // delayed period-start pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                sync_q <= 1'b0;
        else if (restart || start) sync_q <= (sdly == '0);
        else                       sync_q <= tick && (cnt_nxt == sdly);
    end

    assign cnt        = cnt_q;
    assign running    = (st_q == CNT_RUN);
    assign sync_pulse = sync_q;

    // R1: the counter never passes the end value while counting
    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CNT_RUN) |-> (cnt_q <= period));
    // R1: the counter holds between prescale expiries
    a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !sync_in && pre_q < presc) |=> $stable(cnt_q));
    // R9: a sync input leaves the counter at zero
    a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
    // R10: a cleared run bit leaves the counter at zero
    a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt_q == '0));
endmodule

// File: rtl/spwm_edge.sv
module spwm_edge #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] rise,
    input  logic [CNT_W-1:0] fall,
    output logic             level
);
    logic lvl_q;

    // fall compare wins, so equal positions keep the output low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            lvl_q <= 1'b0;
        else if (!running)     lvl_q <= 1'b0;
        else if (cnt == fall)  lvl_q <= 1'b0;
        else if (cnt == rise)  lvl_q <= 1'b1;
    end

    assign level = lvl_q;

    // R4: equal compare positions never raise a low output
    a_r4_equal_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (running && rise == fall && !lvl_q) |=> !lvl_q);
    // R10: a stopped counter drives the output low
    a_r10_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !lvl_q);
endmodule

// File: rtl/spwm_capture.sv
module spwm_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             falling,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_val,
    output logic             hit
);
    logic s1_q, s2_q, s3_q;
    logic [CNT_W-1:0] cap_q;

    // two synchroniser stages plus one history stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign hit = falling ? (s3_q & ~s2_q) : (s2_q & ~s3_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cap_q <= '0;
        else if (hit) cap_q <= cnt;
    end

    assign cap_val = cap_q;

    // R5: the capture register changes only on a detected edge
    a_r5_stable_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cap_q));
endmodule

// File: rtl/sync_pwm_timer.sv
module sync_pwm_timer
    import spwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_OUT = 2,
    parameter int NUM_CAP = 2,
    parameter int ADDR_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CNT_W-1:0]         wr_data,
    input  logic                     sync_in,
    input  logic                     xfer_en_in,
    input  logic [NUM_CAP-1:0]       cap_in,
    output logic [NUM_OUT-1:0]       pwm_out,
    output logic [CNT_W-1:0]         cnt_value,
    output logic [NUM_CAP*CNT_W-1:0] cap_value,
    output logic [NUM_CAP:0]         irq_flags,
    output logic                     irq,
    output logic                     sync_out,
    output logic                     xfer_en_out
);
    localparam int NUM_FLG = NUM_CAP + 1;

    logic [CNT_W-1:0]         period, presc, sdly, cnt;
    logic [NUM_OUT*CNT_W-1:0] rise, fall;
    logic                     run_en, wrap, running;
    logic [NUM_CAP-1:0]       edge_sel, hits;
    logic [NUM_FLG-1:0]       irq_en, flag_clr, flags_q;

    spwm_regs #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT), .NUM_CAP(NUM_CAP), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wrap(wrap), .running(running), .xfer_in(xfer_en_in),
        .act_period(period), .act_presc(presc), .act_sdly(sdly),
        .act_rise(rise), .act_fall(fall), .run_en(run_en), .edge_sel(edge_sel),
        .irq_en(irq_en), .flag_clr(flag_clr), .xfer_out(xfer_en_out)
    );

    spwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .sync_in(sync_in),
        .presc(presc), .period(period), .sdly(sdly),
        .cnt(cnt), .wrap(wrap), .running(running), .sync_pulse(sync_out)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        spwm_edge #(.CNT_W(CNT_W)) u_edge (
            .clk(clk), .rst_n(rst_n), .running(running), .cnt(cnt),
            .rise(rise[i*CNT_W +: CNT_W]), .fall(fall[i*CNT_W +: CNT_W]),
            .level(pwm_out[i])
        );
    end

    for (genvar k = 0; k < NUM_CAP; k++) begin : g_cap
        spwm_capture #(.CNT_W(CNT_W)) u_cap (
            .clk(clk), .rst_n(rst_n), .pin(cap_in[k]), .falling(edge_sel[k]), .cnt(cnt),
            .cap_val(cap_value[k*CNT_W +: CNT_W]), .hit(hits[k])
        );
    end

    // sticky flags: new events win over a clear in the same clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | {hits, wrap};
    end

    assign irq_flags = flags_q;
    assign irq       = |(flags_q & irq_en);
    assign cnt_value = cnt;

    // R7: an interrupt always has a flag behind it
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flags_q));
    // R6: a clear with no new wrap empties the wrap flag
    a_r6_clear_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[0] && !wrap) |=> !flags_q[0]);
endmodule

// File: tb/sync_pwm_timer_test.sv
module sync_pwm_timer_test;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          m_wr_en = 0, s_wr_en = 0;
    logic [3:0]    m_addr = 0, s_addr = 0;
    logic [W-1:0]  m_data = 0, s_data = 0;
    logic          m_sync_in = 0, m_xfer_in = 1;
    logic [1:0]    cap_in = 2'b00;

    logic [1:0]    m_pwm, s_pwm;
    logic [W-1:0]  m_cnt, s_cnt;
    logic [2*W-1:0] m_cap, s_cap;
    logic [2:0]    m_flags, s_flags;
    logic          m_irq, s_irq, m_sync_out, s_sync_out, m_xfer_out, s_xfer_out;

    sync_pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(m_wr_en), .wr_addr(m_addr), .wr_data(m_data),
        .sync_in(m_sync_in), .xfer_en_in(m_xfer_in), .cap_in(cap_in),
        .pwm_out(m_pwm), .cnt_value(m_cnt), .cap_value(m_cap), .irq_flags(m_flags),
        .irq(m_irq), .sync_out(m_sync_out), .xfer_en_out(m_xfer_out)
    );

    sync_pwm_timer slv (
        .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .wr_addr(s_addr), .wr_data(s_data),
        .sync_in(m_sync_out), .xfer_en_in(m_xfer_out), .cap_in(2'b00),
        .pwm_out(s_pwm), .cnt_value(s_cnt), .cap_value(s_cap), .irq_flags(s_flags),
        .irq(s_irq), .sync_out(s_sync_out), .xfer_en_out(s_xfer_out)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    int m_ctrl = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mwr(input int a, input int d);
        m_wr_en = 1; m_addr = 4'(a); m_data = W'(d);
        @(negedge clk);
        m_wr_en = 0;
    endtask

    task automatic swr(input int a, input int d);
        s_wr_en = 1; s_addr = 4'(a); s_data = W'(d);
        @(negedge clk);
        s_wr_en = 0;
    endtask

    task automatic max_cnt(input bit slave, input int n, output int mx);
        mx = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (slave) begin if (int'(s_cnt) > mx) mx = int'(s_cnt); end
            else       begin if (int'(m_cnt) > mx) mx = int'(m_cnt); end
        end
    endtask

    task automatic restart_master();
        while (m_cnt == 0) @(negedge clk);
        m_sync_in = 1;
        @(negedge clk);
        m_sync_in = 0;
    endtask

    task automatic t_reset();
        check(m_cnt == 0 && m_pwm == 0, "R10 reset counter/outputs", int'(m_cnt), 0);
        check(m_irq == 0 && m_flags == 0, "R7 reset irq/flags", int'(m_flags), 0);
        check(m_sync_out == 0 && m_xfer_out == 0, "R3 reset sync/permit", int'(m_xfer_out), 0);
    endtask

    task automatic t_period();
        int last, run, changes, bad;
        mwr(0, 4); mwr(1, 2);
        mwr(2, 2);
        @(negedge clk);
        m_ctrl = 1; mwr(2, m_ctrl);
        last = int'(m_cnt); run = 1; changes = 0; bad = 0;
        for (int i = 0; i < 45; i++) begin
            @(negedge clk);
            if (int'(m_cnt) == last) run++;
            else begin
                if (changes > 0 && run != 3) bad++;
                if (int'(m_cnt) != ((last == 4) ? 0 : last + 1)) bad++;
                changes++; last = int'(m_cnt); run = 1;
            end
        end
        check(bad == 0, "R1 step length and wrap order", bad, 0);
        check(changes >= 10, "R1 counter advances", changes, 10);
    endtask

    task automatic t_shadow();
        int mx;
        mwr(0, 7);
        max_cnt(0, 40, mx);
        check(mx == 4, "R2 shadow write has no effect", mx, 4);
        mwr(2, m_ctrl | 2);
        repeat (30) @(negedge clk);
        max_cnt(0, 60, mx);
        check(mx == 7, "R2 update applied at wrap", mx, 7);
    endtask

    task automatic t_permit();
        int mx;
        bit seen;
        m_xfer_in = 0;
        mwr(0, 9); mwr(2, m_ctrl | 2);
        max_cnt(0, 60, mx);
        check(mx == 7, "R3 no transfer without permit", mx, 7);
        m_xfer_in = 1;
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (m_xfer_out) seen = 1;
        end
        check(seen, "R3 permit output raised after transfer", int'(seen), 1);
        max_cnt(0, 80, mx);
        check(mx == 9, "R3 transfer once permitted", mx, 9);
        check(m_xfer_out == 0, "R3 permit output dropped after plain wrap", int'(m_xfer_out), 0);
        mwr(0, 7); mwr(2, m_ctrl | 2);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_outputs();
        int prev, bad0, bad1;
        bit exp0;
        mwr(8, 2); mwr(9, 5); mwr(10, 3); mwr(11, 3);
        mwr(2, m_ctrl | 2);
        repeat (40) @(negedge clk);
        prev = int'(m_cnt); bad0 = 0; bad1 = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            exp0 = (prev >= 2 && prev < 5);
            if (m_pwm[0] != exp0) bad0++;
            if (m_pwm[1] != 1'b0) bad1++;
            prev = int'(m_cnt);
        end
        check(bad0 == 0, "R4 rise/fall positions", bad0, 0);
        check(bad1 == 0, "R4 equal positions stay low", bad1, 0);
    endtask

    task automatic t_sync_out(input int dly);
        int prev, bad, pulses;
        bit exp;
        mwr(3, dly); mwr(2, m_ctrl | 2);
        repeat (40) @(negedge clk);
        prev = int'(m_cnt); bad = 0; pulses = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            exp = (int'(m_cnt) == dly) && (prev != dly);
            if (m_sync_out != exp) bad++;
            if (m_sync_out) pulses++;
            prev = int'(m_cnt);
        end
        check(bad == 0, "R8 sync pulse position", bad, 0);
        check(pulses >= 3, "R8 sync pulses seen", pulses, 3);
    endtask

    task automatic t_restart();
        restart_master();
        check(m_cnt == 0, "R9 sync input clears counter", int'(m_cnt), 0);
        check(m_sync_out == 1, "R8 zero delay pulses on restart", int'(m_sync_out), 1);
    endtask

    task automatic t_capture();
        mwr(0, 50); mwr(1, 19);
        m_ctrl = 1 | (1 << 3);
        mwr(2, m_ctrl | 2);
        repeat (40) @(negedge clk);
        mwr(4, 7);
        restart_master();
        repeat (110) @(negedge clk);
        cap_in[0] = 1;
        repeat (4) @(negedge clk);
        check(m_cap[W-1:0] == 5, "R5 rising capture value", int'(m_cap[W-1:0]), 5);
        check(m_flags[1] == 1, "R6 capture flag set", int'(m_flags[1]), 1);
        restart_master();
        repeat (50) @(negedge clk);
        cap_in[1] = 1;
        repeat (5) @(negedge clk);
        check(m_cap[2*W-1:W] == 0, "R5 wrong polarity ignored", int'(m_cap[2*W-1:W]), 0);
        check(m_flags[2] == 0, "R5 wrong polarity sets no flag", int'(m_flags[2]), 0);
        restart_master();
        repeat (70) @(negedge clk);
        cap_in[1] = 0;
        repeat (4) @(negedge clk);
        check(m_cap[2*W-1:W] == 3, "R5 falling capture value", int'(m_cap[2*W-1:W]), 3);
        check(m_cap[W-1:0] == 5, "R5 other capture untouched", int'(m_cap[W-1:0]), 5);
        mwr(4, 2);
        check(m_flags[2:1] == 2'b10, "R6 clear only selected flag", int'(m_flags[2:1]), 2);
        mwr(4, 4);
        check(m_flags[2] == 0, "R6 clear second flag", int'(m_flags[2]), 0);
    endtask

    task automatic t_irq();
        mwr(4, 1);
        while (!m_flags[0]) @(negedge clk);
        check(m_irq == 0, "R7 disabled flag gives no irq", int'(m_irq), 0);
        mwr(2, m_ctrl | (1 << 8));
        check(m_irq == 1, "R7 enabled flag raises irq", int'(m_irq), 1);
        mwr(4, 1);
        check(m_irq == 0 && m_flags[0] == 0, "R6 R7 clear drops irq", int'(m_irq), 0);
        mwr(2, m_ctrl);
    endtask

    task automatic t_chain();
        int mx, bad;
        bit prev_sync;
        swr(0, 5); swr(1, 1); swr(2, 2);
        swr(2, 1);
        max_cnt(1, 40, mx);
        check(mx == 0, "R3 slave waits for master transfer", mx, 0);
        mwr(0, 7); mwr(1, 2); mwr(2, m_ctrl | 2);
        repeat (1100) @(negedge clk);
        mx = 0; bad = 0; prev_sync = m_sync_out;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (prev_sync && s_cnt != 0) bad++;
            if (int'(s_cnt) > mx) mx = int'(s_cnt);
            prev_sync = m_sync_out;
        end
        check(mx == 5, "R3 slave transfer after master", mx, 5);
        check(bad == 0, "R9 slave restarts after master sync", bad, 0);
    endtask

    task automatic t_stop();
        m_ctrl = 0; mwr(2, 0);
        repeat (2) @(negedge clk);
        check(m_cnt == 0, "R10 stop clears counter", int'(m_cnt), 0);
        check(m_pwm == 0, "R10 stop drives outputs low", int'(m_pwm), 0);
        repeat (30) @(negedge clk);
        check(m_cnt == 0 && m_pwm == 0, "R10 stays stopped", int'(m_cnt), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_period();
        t_shadow();
        t_permit();
        t_outputs();
        t_sync_out(3);
        t_sync_out(0);
        t_restart();
        t_capture();
        t_irq();
        t_chain();
        t_stop();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule